// File: doc/BRIEF.md
# SCSI Controller Register File and Command Decoder

This block is the host-facing front end of a small SCSI bus controller. A byte-wide bus with a 4-bit address reaches a set of registers: a transfer counter, a data FIFO port, a command register, status, interrupt and sequence-step registers, a FIFO byte count and a configuration byte. A byte written to the command register is decoded into an action. The action updates the status, interrupt and sequence registers and raises or lowers the single interrupt line.

Bus phases, target selection, bus signalling and DMA data movement belong to other blocks. For those the decoder only emits one-cycle action pulses and a DMA-mode level. A separate input tells the block when host writes to the FIFO port belong to a command being collected. Those bytes leave on a strobe and do not enter the data FIFO.

Register map (address: read / write): 0 and 1 counter low/high byte / counter load value; 2 FIFO pop / FIFO push; 3 last command / command; 4 status / ignored; 5 interrupt reason (read clears) / ignored; 6 sequence step / ignored; 7 FIFO byte count / ignored; 8 configuration / configuration; 9 to 15 read 0 / ignored.

Top module: `scsi_cmd_regfile`

## Requirements
- R1: After reset every readable register (0 to 8) reads 0x00, and `irq_o` and `dma_mode_o` are low.
- R2: Writes to registers 0 and 1 only store a load value; registers 0/1 keep their read value. A command write with bit 7 set drives `dma_mode_o` high and copies the stored load values into registers 0/1. A command write with bit 7 clear drives `dma_mode_o` low.
- R3: Bits 6:0 of a command select the operation. Codes 0x10, 0x11, 0x12, 0x1A, 0x42, 0x43, 0x44 and 0x03 each give a one-cycle pulse on their own output in the cycle after the write. Codes 0x00 and any code not listed give no pulse and leave registers 4, 5 and 6 unchanged, while register 3 still reads back the byte written.
- R4: Command 0x01 sets register 5 to 0x08 (function done) and register 6 to 0.
- R5: Command 0x03 sets register 5 to 0x80 (bus reset seen) and raises `irq_o` only when bit 6 of register 8 is 0.
- R6: Command 0x11 raises `irq_o`. With bit 7 set it ORs 0x98 into register 4 (bit 7 interrupt pending, bit 4 terminal count, bit 3 status phase), sets register 5 to 0x18 and register 6 to 4. With bit 7 clear it loads the FIFO with two 0x00 bytes, so register 7 reads 2.
- R7: Command 0x12 performs the R6 action and then sets register 5 to 0x20 (disconnect) and register 6 to 0.
- R8: A read of register 5 clears bits 7, 6 and 5 of register 4 and drops `irq_o` in the following cycle.
- R9: Writes to register 2 push bytes, and reads of register 2 return them in order. Register 7 gives the count. A read that pops a byte raises `irq_o`. When the count reaches 0 the FIFO pointers return to 0.
- R10: The FIFO holds 16 bytes. A push to a full FIFO is dropped, even when a pop happens in the same cycle. A read of an empty FIFO returns the last byte popped, does not change the count and does not raise `irq_o`.
- R11: While `cmd_collect_i` is high, a write to register 2 gives a one-cycle `cmd_byte_vld_o` with the byte on `cmd_byte_o`, and the FIFO count is unchanged.
- R12: Command 0x02 clears all registers, the FIFO, `dma_mode_o` and `irq_o` at the second clock edge after the write. Bus accesses in that cycle are ignored.
- R13: Register 8 reads back the last byte written to it. A write to register 0 or 1 clears bit 4 (terminal count) of register 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Register address |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rd_en_i | input | 1 | Read strobe (has side effects on registers 2 and 5) |
| rdata_o | output | 8 | Read data, combinational from `addr_i` |
| cmd_collect_i | input | 1 | Route FIFO-port writes to the command byte strobe |
| irq_o | output | 1 | Interrupt line |
| dma_mode_o | output | 1 | DMA mode taken from the last command |
| xfer_o | output | 1 | Pulse: transfer information (0x10) |
| cmd_cplt_o | output | 1 | Pulse: command-complete sequence (0x11) |
| msg_acc_o | output | 1 | Pulse: message accepted (0x12) |
| set_atn_o | output | 1 | Pulse: assert attention (0x1A) |
| sel_atn_o | output | 1 | Pulse: select with attention (0x42) |
| sel_atn_stop_o | output | 1 | Pulse: select with attention and stop (0x43) |
| en_sel_o | output | 1 | Pulse: enable selection (0x44) |
| bus_rst_o | output | 1 | Pulse: bus reset (0x03) |
| cmd_byte_vld_o | output | 1 | Pulse: command byte collected |
| cmd_byte_o | output | 8 | Collected command byte |

## Verification
The FIFO push and the FIFO pop can occur in the same cycle when the host asserts both strobes at address 2. The bench does this with a single byte in the FIFO, where the count must stay at 1 and the pointers must not reset. It does it again with a full FIFO, where the pop must succeed and the push must be dropped. Each case is judged by the byte returned in that cycle, the count in register 7 afterwards, and the order of the bytes popped later.

// File: rtl/scsi_cmd_pkg.sv
package scsi_cmd_pkg;
  localparam int unsigned DW = 8;

  localparam logic [3:0] A_CNT_LO = 4'd0;
  localparam logic [3:0] A_CNT_HI = 4'd1;
  localparam logic [3:0] A_FIFO   = 4'd2;
  localparam logic [3:0] A_CMD    = 4'd3;
  localparam logic [3:0] A_STAT   = 4'd4;
  localparam logic [3:0] A_INTR   = 4'd5;
  localparam logic [3:0] A_SEQ    = 4'd6;
  localparam logic [3:0] A_FLAGS  = 4'd7;
  localparam logic [3:0] A_CFG    = 4'd8;

  localparam logic [7:0] ST_TC_M     = 8'h10;
  localparam logic [7:0] ST_CLR_M    = 8'hE0; // int pending, gross err, parity err
  localparam logic [7:0] ST_RSP_M    = 8'h98; // int pending, tc, status phase
  localparam logic [7:0] IN_RST_M    = 8'h80;
  localparam logic [7:0] IN_DISC_M   = 8'h20;
  localparam logic [7:0] IN_RSP_M    = 8'h18; // bus service, function done
  localparam logic [7:0] IN_FDONE_M  = 8'h08;
  localparam logic [7:0] SEQ_RSP     = 8'd4;
  localparam int unsigned CFG_NOIRQ_BIT = 6;

  typedef enum logic [6:0] {
    OP_NOP          = 7'h00,
    OP_FLUSH        = 7'h01,
    OP_CHIP_RST     = 7'h02,
    OP_BUS_RST      = 7'h03,
    OP_XFER         = 7'h10,
    OP_CPLT         = 7'h11,
    OP_MSG_ACC      = 7'h12,
    OP_SET_ATN      = 7'h1A,
    OP_SEL_ATN      = 7'h42,
    OP_SEL_ATN_STOP = 7'h43,
    OP_EN_SEL       = 7'h44
  } op_e;

  typedef struct packed {
    logic flush;
    logic chip_rst;
    logic bus_rst;
    logic xfer;
    logic cplt;
    logic msg_acc;
    logic set_atn;
    logic sel_atn;
    logic sel_atn_stop;
    logic en_sel;
  } act_t;
endpackage

// File: rtl/scsi_op_decode.sv
module scsi_op_decode
  import scsi_cmd_pkg::*;
(
  input  logic       valid_i,
  input  logic [6:0] op_i,
  output act_t       act_o
);
  always_comb begin
    act_o = '0;
    if (valid_i) begin
      case (op_i)
        OP_FLUSH:        act_o.flush        = 1'b1;
        OP_CHIP_RST:     act_o.chip_rst     = 1'b1;
        OP_BUS_RST:      act_o.bus_rst      = 1'b1;
        OP_XFER:         act_o.xfer         = 1'b1;
        OP_CPLT:         act_o.cplt         = 1'b1;
        OP_MSG_ACC:      act_o.msg_acc      = 1'b1;
        OP_SET_ATN:      act_o.set_atn      = 1'b1;
        OP_SEL_ATN:      act_o.sel_atn      = 1'b1;
        OP_SEL_ATN_STOP: act_o.sel_atn_stop = 1'b1;
        OP_EN_SEL:       act_o.en_sel       = 1'b1;
        default:         act_o = '0; // nop and unknown codes
      endcase
    end
  end
endmodule

// File: rtl/scsi_byte_fifo.sv
module scsi_byte_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          load_pair_i,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic [CW-1:0] count_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wptr_q, rptr_q, wptr_nx, rptr_nx;
  logic [CW-1:0] cnt_q, cnt_nx;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // push decided on the count before any same-cycle pop
  assign do_push = push_i && (cnt_q < CW'(DEPTH));
  assign do_pop  = pop_i && (cnt_q != '0);

  always_comb begin
    wptr_nx = do_push ? ptr_inc(wptr_q) : wptr_q;
    rptr_nx = do_pop  ? ptr_inc(rptr_q) : rptr_q;
    cnt_nx  = cnt_q + CW'(do_push) - CW'(do_pop);
    if (cnt_nx == '0) begin
      wptr_nx = '0;
      rptr_nx = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= '0;
    end else if (clr_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (load_pair_i) begin
      mem_q[0] <= '0;
      mem_q[1] <= '0;
      wptr_q   <= PW'(2 % DEPTH);
      rptr_q   <= '0;
      cnt_q    <= CW'(2);
    end else begin
      if (do_push) mem_q[wptr_q] <= data_i;
      wptr_q <= wptr_nx;
      rptr_q <= rptr_nx;
      cnt_q  <= cnt_nx;
    end
  end

  assign head_o  = mem_q[rptr_q];
  assign count_o = cnt_q;
endmodule

// File: rtl/scsi_cmd_regfile.sv
module scsi_cmd_regfile
  import scsi_cmd_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 16,
  localparam int unsigned CW        = $clog2(FIFO_DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [3:0]    addr_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_en_i,
  output logic [DW-1:0] rdata_o,
  input  logic          cmd_collect_i,
  output logic          irq_o,
  output logic          dma_mode_o,
  output logic          xfer_o,
  output logic          cmd_cplt_o,
  output logic          msg_acc_o,
  output logic          set_atn_o,
  output logic          sel_atn_o,
  output logic          sel_atn_stop_o,
  output logic          en_sel_o,
  output logic          bus_rst_o,
  output logic          cmd_byte_vld_o,
  output logic [DW-1:0] cmd_byte_o
);
  logic [DW-1:0] ld_lo_q, ld_hi_q, cnt_lo_q, cnt_hi_q;
  logic [DW-1:0] cmd_q, stat_q, intr_q, seq_q, cfg_q, last_q;
  logic [DW-1:0] stat_nx, intr_nx, seq_nx;
  logic          dma_q, irq_q, rst_pend_q;
  logic          cbv_q;
  logic [DW-1:0] cb_q;
  act_t          act, act_q;

  logic          bus_ok, wr_ok, rd_ok, wr_cmd, rsp, rsp_dma;
  logic          fifo_push, fifo_pop, fifo_load, irq_set, irq_clr;
  logic [DW-1:0] fifo_head;
  logic [CW-1:0] fifo_cnt;

  assign bus_ok = !rst_pend_q;
  assign wr_ok  = wr_en_i && bus_ok;
  assign rd_ok  = rd_en_i && bus_ok;
  assign wr_cmd = wr_ok && (addr_i == A_CMD);

  scsi_op_decode u_dec (
    .valid_i (wr_cmd),
    .op_i    (wdata_i[6:0]),
    .act_o   (act)
  );

  assign rsp       = act.cplt || act.msg_acc;
  assign rsp_dma   = rsp && wdata_i[7];
  assign fifo_load = rsp && !wdata_i[7];
  assign fifo_push = wr_ok && (addr_i == A_FIFO) && !cmd_collect_i;
  assign fifo_pop  = rd_ok && (addr_i == A_FIFO) && (fifo_cnt != '0);
  assign irq_set   = fifo_pop || rsp || (act.bus_rst && !cfg_q[CFG_NOIRQ_BIT]);
  assign irq_clr   = rd_ok && (addr_i == A_INTR);

  scsi_byte_fifo #(
    .DEPTH (FIFO_DEPTH),
    .DW    (DW)
  ) u_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (rst_pend_q),
    .load_pair_i (fifo_load),
    .push_i      (fifo_push),
    .data_i      (wdata_i),
    .pop_i       (fifo_pop),
    .head_o      (fifo_head),
    .count_o     (fifo_cnt)
  );

  // status, interrupt reason and sequence step: later terms take priority
  always_comb begin
    stat_nx = stat_q;
    intr_nx = intr_q;
    seq_nx  = seq_q;
    if (wr_ok && (addr_i == A_CNT_LO || addr_i == A_CNT_HI)) stat_nx = stat_nx & ~ST_TC_M;
    if (irq_clr) stat_nx = stat_nx & ~ST_CLR_M;
    if (act.flush) begin
      intr_nx = IN_FDONE_M;
      seq_nx  = '0;
    end
    if (act.bus_rst) intr_nx = IN_RST_M;
    if (rsp_dma) begin
      stat_nx = stat_nx | ST_RSP_M;
      intr_nx = IN_RSP_M;
      seq_nx  = SEQ_RSP;
    end
    if (act.msg_acc) begin
      intr_nx = IN_DISC_M;
      seq_nx  = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni || rst_pend_q) begin
      ld_lo_q    <= '0;
      ld_hi_q    <= '0;
      cnt_lo_q   <= '0;
      cnt_hi_q   <= '0;
      cmd_q      <= '0;
      stat_q     <= '0;
      intr_q     <= '0;
      seq_q      <= '0;
      cfg_q      <= '0;
      last_q     <= '0;
      dma_q      <= 1'b0;
      irq_q      <= 1'b0;
      rst_pend_q <= 1'b0;
      act_q      <= '0;
      cbv_q      <= 1'b0;
      cb_q       <= '0;
    end else begin
      stat_q     <= stat_nx;
      intr_q     <= intr_nx;
      seq_q      <= seq_nx;
      act_q      <= act;
      rst_pend_q <= act.chip_rst;
      cbv_q      <= wr_ok && (addr_i == A_FIFO) && cmd_collect_i;
      if (wr_ok && (addr_i == A_FIFO) && cmd_collect_i) cb_q <= wdata_i;
      if (fifo_pop) last_q <= fifo_head;
      if (irq_set)      irq_q <= 1'b1;
      else if (irq_clr) irq_q <= 1'b0;
      if (wr_ok) begin
        case (addr_i)
          A_CNT_LO: ld_lo_q <= wdata_i;
          A_CNT_HI: ld_hi_q <= wdata_i;
          A_CMD: begin
            cmd_q <= wdata_i;
            dma_q <= wdata_i[7];
            if (wdata_i[7]) begin
              cnt_lo_q <= ld_lo_q;
              cnt_hi_q <= ld_hi_q;
            end
          end
          A_CFG:   cfg_q <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr_i)
      A_CNT_LO: rdata_o = cnt_lo_q;
      A_CNT_HI: rdata_o = cnt_hi_q;
      A_FIFO:   rdata_o = (fifo_cnt != '0) ? fifo_head : last_q;
      A_CMD:    rdata_o = cmd_q;
      A_STAT:   rdata_o = stat_q;
      A_INTR:   rdata_o = intr_q;
      A_SEQ:    rdata_o = seq_q;
      A_FLAGS:  rdata_o = 8'(fifo_cnt);
      A_CFG:    rdata_o = cfg_q;
      default:  rdata_o = '0;
    endcase
  end

  assign irq_o          = irq_q;
  assign dma_mode_o     = dma_q;
  assign xfer_o         = act_q.xfer;
  assign cmd_cplt_o     = act_q.cplt;
  assign msg_acc_o      = act_q.msg_acc;
  assign set_atn_o      = act_q.set_atn;
  assign sel_atn_o      = act_q.sel_atn;
  assign sel_atn_stop_o = act_q.sel_atn_stop;
  assign en_sel_o       = act_q.en_sel;
  assign bus_rst_o      = act_q.bus_rst;
  assign cmd_byte_vld_o = cbv_q;
  assign cmd_byte_o     = cb_q;
endmodule

// File: rtl/scsi_cmd_regfile_chk.sv
module scsi_cmd_regfile_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CW    = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [3:0]    addr_i,
  input logic          wr_en_i,
  input logic [7:0]    wdata_i,
  input logic          rd_en_i,
  input logic          cmd_collect_i,
  input logic          irq_o,
  input logic          dma_mode_o,
  input logic          xfer_o,
  input logic          cmd_cplt_o,
  input logic          msg_acc_o,
  input logic          set_atn_o,
  input logic          sel_atn_o,
  input logic          sel_atn_stop_o,
  input logic          en_sel_o,
  input logic          bus_rst_o,
  input logic [CW-1:0] fifo_cnt_i,
  input logic          rst_pend_i,
  input logic [7:0]    cfg_i
);
  assert_dma_follow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 4'd3 && !rst_pend_i) |=> (dma_mode_o == $past(wdata_i[7])));

  assert_pulse_onehot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({xfer_o, cmd_cplt_o, msg_acc_o, set_atn_o, sel_atn_o, sel_atn_stop_o,
              en_sel_o, bus_rst_o}));

  assert_xfer_source_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_o |-> $past(wr_en_i && addr_i == 4'd3 && wdata_i[6:0] == 7'h10 && !rst_pend_i));

  assert_bus_rst_irq_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rst_o && !cfg_i[6]) |-> irq_o);

  assert_intr_read_drop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == 4'd5 && !rst_pend_i) |=> !irq_o);

  assert_no_overflow_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_cnt_i <= CW'(DEPTH));

  assert_collect_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 4'd2 && cmd_collect_i && !rd_en_i && !rst_pend_i)
      |=> $stable(fifo_cnt_i));

  assert_chip_rst_clear_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_pend_i |=> (!irq_o && !dma_mode_o && fifo_cnt_i == '0));
endmodule

bind scsi_cmd_regfile scsi_cmd_regfile_chk #(
  .DEPTH (FIFO_DEPTH),
  .CW    (CW)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .addr_i         (addr_i),
  .wr_en_i        (wr_en_i),
  .wdata_i        (wdata_i),
  .rd_en_i        (rd_en_i),
  .cmd_collect_i  (cmd_collect_i),
  .irq_o          (irq_o),
  .dma_mode_o     (dma_mode_o),
  .xfer_o         (xfer_o),
  .cmd_cplt_o     (cmd_cplt_o),
  .msg_acc_o      (msg_acc_o),
  .set_atn_o      (set_atn_o),
  .sel_atn_o      (sel_atn_o),
  .sel_atn_stop_o (sel_atn_stop_o),
  .en_sel_o       (en_sel_o),
  .bus_rst_o      (bus_rst_o),
  .fifo_cnt_i     (fifo_cnt),
  .rst_pend_i     (rst_pend_q),
  .cfg_i          (cfg_q)
);

// File: tb/tb_scsi_cmd_regfile.sv
module tb_scsi_cmd_regfile;
  localparam int CLK_P = 10;
  localparam int NV    = 41;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0, collect = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, cmd_byte;
  logic       irq, dma, xfer, cplt, macc, satn, sel, sels, ensel, brst, cbv;
  int         n_chk = 0, n_fail = 0;

  always #(CLK_P / 2) clk = ~clk;

  scsi_cmd_regfile dut (
    .clk_i (clk), .rst_ni (rst_n), .addr_i (addr), .wr_en_i (wr_en), .wdata_i (wdata),
    .rd_en_i (rd_en), .rdata_o (rdata), .cmd_collect_i (collect), .irq_o (irq),
    .dma_mode_o (dma), .xfer_o (xfer), .cmd_cplt_o (cplt), .msg_acc_o (macc),
    .set_atn_o (satn), .sel_atn_o (sel), .sel_atn_stop_o (sels), .en_sel_o (ensel),
    .bus_rst_o (brst), .cmd_byte_vld_o (cbv), .cmd_byte_o (cmd_byte)
  );

  // {req[3:0], is_read, addr[3:0], data[7:0], expected[7:0]}
  localparam logic [24:0] VEC [NV] = '{
    {4'd13, 1'b0, 4'h8, 8'h00, 8'h00}, {4'd13, 1'b1, 4'h8, 8'h00, 8'h00}, // R13
    {4'd2,  1'b0, 4'h0, 8'h34, 8'h00}, {4'd2,  1'b0, 4'h1, 8'h12, 8'h00},
    {4'd2,  1'b1, 4'h0, 8'h00, 8'h00}, {4'd2,  1'b0, 4'h3, 8'h80, 8'h00}, // R2
    {4'd2,  1'b1, 4'h0, 8'h00, 8'h34}, {4'd2,  1'b1, 4'h1, 8'h00, 8'h12},
    {4'd3,  1'b1, 4'h3, 8'h00, 8'h80}, {4'd4,  1'b0, 4'h3, 8'h01, 8'h00}, // R4
    {4'd4,  1'b1, 4'h5, 8'h00, 8'h08}, {4'd4,  1'b1, 4'h6, 8'h00, 8'h00},
    {4'd9,  1'b0, 4'h2, 8'hA1, 8'h00}, {4'd9,  1'b0, 4'h2, 8'hB2, 8'h00}, // R9
    {4'd9,  1'b1, 4'h7, 8'h00, 8'h02}, {4'd9,  1'b1, 4'h2, 8'h00, 8'hA1},
    {4'd9,  1'b1, 4'h2, 8'h00, 8'hB2}, {4'd9,  1'b1, 4'h7, 8'h00, 8'h00},
    {4'd10, 1'b1, 4'h2, 8'h00, 8'hB2}, {4'd6,  1'b0, 4'h3, 8'h91, 8'h00}, // R10, R6
    {4'd6,  1'b1, 4'h4, 8'h00, 8'h98}, {4'd6,  1'b1, 4'h6, 8'h00, 8'h04},
    {4'd6,  1'b1, 4'h5, 8'h00, 8'h18}, {4'd8,  1'b1, 4'h4, 8'h00, 8'h18}, // R8
    {4'd13, 1'b0, 4'h0, 8'h00, 8'h00}, {4'd13, 1'b1, 4'h4, 8'h00, 8'h08},
    {4'd7,  1'b0, 4'h3, 8'h12, 8'h00}, {4'd7,  1'b1, 4'h7, 8'h00, 8'h02}, // R7
    {4'd7,  1'b1, 4'h5, 8'h00, 8'h20}, {4'd7,  1'b1, 4'h6, 8'h00, 8'h00},
    {4'd7,  1'b1, 4'h2, 8'h00, 8'h00}, {4'd7,  1'b1, 4'h2, 8'h00, 8'h00},
    {4'd7,  1'b1, 4'h7, 8'h00, 8'h00}, {4'd5,  1'b0, 4'h3, 8'h03, 8'h00}, // R5
    {4'd5,  1'b1, 4'h5, 8'h00, 8'h80}, {4'd13, 1'b0, 4'h8, 8'h5A, 8'h00},
    {4'd13, 1'b1, 4'h8, 8'h00, 8'h5A}, {4'd3,  1'b0, 4'h3, 8'h7F, 8'h00}, // R3
    {4'd3,  1'b1, 4'h5, 8'h00, 8'h80}, {4'd3,  1'b1, 4'h3, 8'h00, 8'h7F},
    {4'd3,  1'b1, 4'h6, 8'h00, 8'h00}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] got);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 got = rdata;
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic rdwr(input logic [7:0] d, output logic [7:0] got);
    @(negedge clk);
    addr = 4'h2; wdata = d; rd_en = 1'b1; wr_en = 1'b1;
    #1 got = rdata;
    @(posedge clk); #1;
    rd_en = 1'b0; wr_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [7:0] got;
    logic [7:0] codes [7];
    codes = '{8'h10, 8'h11, 8'h12, 8'h1A, 8'h42, 8'h43, 8'h44};

    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state
    for (int a = 0; a < 9; a++) begin
      rd(4'(a), got);
      check("R1", got, 8'h00);
    end
    check("R1", {7'd0, irq}, 8'h00);
    check("R1", {7'd0, dma}, 8'h00);

    // table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][20]) begin
        rd(VEC[i][19:16], got);
        check($sformatf("R%0d vec%0d", VEC[i][24:21], i), got, VEC[i][7:0]);
      end else begin
        wr(VEC[i][19:16], VEC[i][15:8]);
      end
    end

    // R2: dma level follows bit 7
    wr(4'h3, 8'h80); check("R2", {7'd0, dma}, 8'h01);
    wr(4'h3, 8'h00); check("R2", {7'd0, dma}, 8'h00);

    // R3: one pulse per code, none for nop/unknown
    for (int k = 0; k < 7; k++) begin
      wr(4'h3, codes[k]);
      check("R3 pulse", {xfer, cplt, macc, satn, sel, sels, ensel, brst}, 8'h80 >> k);
      @(posedge clk); #1;
      check("R3 width", {xfer, cplt, macc, satn, sel, sels, ensel, brst}, 8'h00);
    end
    wr(4'h3, 8'h03); check("R3 bus rst", {7'd0, brst}, 8'h01);
    wr(4'h3, 8'h00); check("R3 nop", {xfer, cplt, macc, satn, sel, sels, ensel, brst}, 8'h00);
    wr(4'h3, 8'h55); check("R3 unknown", {xfer, cplt, macc, satn, sel, sels, ensel, brst}, 8'h00);

    // R12: chip reset, visible two edges after the write
    wr(4'h8, 8'h5A);
    wr(4'h2, 8'h99);
    wr(4'h3, 8'h82);
    check("R12 pending", {7'd0, dma}, 8'h01);
    @(posedge clk); #1;
    check("R12 irq", {7'd0, irq}, 8'h00);
    check("R12 dma", {7'd0, dma}, 8'h00);
    rd(4'h7, got); check("R12 count", got, 8'h00);
    rd(4'h8, got); check("R12 cfg", got, 8'h00);
    rd(4'h5, got); check("R12 intr", got, 8'h00);
    rd(4'h3, got); check("R12 cmd", got, 8'h00);

    // R5: masked bus reset interrupt
    wr(4'h8, 8'h40);
    wr(4'h3, 8'h03);
    check("R5 masked", {7'd0, irq}, 8'h00);
    rd(4'h5, got); check("R5 reason", got, 8'h80);
    wr(4'h8, 8'h00);
    wr(4'h3, 8'h03);
    check("R5 unmasked", {7'd0, irq}, 8'h01);
    rd(4'h5, got);
    check("R8 irq drop", {7'd0, irq}, 8'h00);

    // R9: pop raises irq
    wr(4'h2, 8'h3C);
    check("R9 push no irq", {7'd0, irq}, 8'h00);
    rd(4'h2, got);
    check("R9 data", got, 8'h3C);
    check("R9 irq", {7'd0, irq}, 8'h01);
    rd(4'h5, got);
    rd(4'h2, got);
    check("R10 empty data", got, 8'h3C);
    check("R10 empty irq", {7'd0, irq}, 8'h00);

    // R11: command collection bypasses the FIFO
    collect = 1'b1;
    wr(4'h2, 8'h55);
    collect = 1'b0;
    check("R11 strobe", {7'd0, cbv}, 8'h01);
    check("R11 byte", cmd_byte, 8'h55);
    rd(4'h7, got); check("R11 count", got, 8'h00);

    // same-cycle push and pop with one byte held
    wr(4'h2, 8'h77);
    rdwr(8'h88, got);
    check("R9 collide data", got, 8'h77);
    rd(4'h7, got); check("R9 collide count", got, 8'h01);
    rd(4'h2, got); check("R9 collide order", got, 8'h88);

    // R10: full FIFO
    for (int k = 0; k < 17; k++) wr(4'h2, 8'h10 + 8'(k));
    rd(4'h7, got); check("R10 full count", got, 8'd16);
    rdwr(8'hEE, got);
    check("R10 full collide data", got, 8'h10);
    rd(4'h7, got); check("R10 full collide count", got, 8'd15);
    for (int k = 1; k < 16; k++) begin
      rd(4'h2, got);
      check("R10 drain", got, 8'h10 + 8'(k));
    end
    rd(4'h7, got); check("R10 drained", got, 8'h00);

    finish_run();
  end
endmodule